// File: doc/BRIEF.md
# Bufferless Deflection Torus Router Node

This block is one node of a two-dimensional network-on-chip laid out as a torus, where every ring carries traffic in one direction only. Each node has one incoming link from its X ring, one from its Y ring, and a port through which a local client injects messages. It drives one outgoing link onto each ring and a delivery port toward the client. A message is a single wide flit that holds a valid bit, a destination column, a destination row and a payload. Routing is dimension-ordered. A flit first rides the X ring until its column matches the node, then rides the Y ring until its row matches.

The router never stores a flit. Every flit on a ring input leaves through a registered output in the next cycle. When two flits want the same output, the loser is deflected onward along the ring it arrived on and makes another lap. The client is the only source that can be refused. Its request is accepted only when the output it targets is not taken by ring traffic in that cycle. Each output needs only a single four-way select per bit ahead of its register.

Top module: `tor_router`

## Requirements
- R1: While reset is asserted and in the cycle after the synchronised reset releases, bit 0 (valid) of `x_out`, `y_out` and `dlv_out` is 0. The flit layout is: bit 0 valid, then the destination column in the next log2(X_NODES) bits, then the destination row in the next log2(Y_NODES) bits, then the payload in the top bits.
- R2: Every output is registered. A flit presented on an input in one cycle appears on an output after the next rising clock edge, with its coordinates and payload unchanged.
- R3: A valid `y_in` flit whose row equals `my_y` appears on `dlv_out` in the next cycle.
- R4: A valid `y_in` flit whose row differs from `my_y` appears on `y_out` in the next cycle. It has first claim on that output.
- R5: A valid `x_in` flit whose column differs from `my_x` appears on `x_out` in the next cycle. This covers destinations that lie across the ring's wrap point.
- R6: A valid `x_in` flit whose column matches but whose row differs turns onto `y_out` when no `y_in` flit holds `y_out`. Otherwise it is deflected onto `x_out`.
- R7: A valid `x_in` flit whose column and row both match goes to `dlv_out` when no `y_in` flit is being delivered. Otherwise it is deflected onto `x_out`.
- R8: The client flit targets an output by the same rule as `x_in`: column mismatch selects X, row mismatch selects Y, a full match selects delivery. `inj_ready` is high only when the client flit is valid and its target output is unclaimed by ring traffic. An accepted flit appears on its target in the next cycle. A refused flit appears on no output.
- R9: No ring flit is ever lost. The number of valid outputs in a cycle is at least the number of valid ring inputs in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| my_x | input | log2(X_NODES) | Column of this node |
| my_y | input | log2(Y_NODES) | Row of this node |
| x_in | input | FLIT_W | Flit arriving on the X ring |
| y_in | input | FLIT_W | Flit arriving on the Y ring |
| inj_flit | input | FLIT_W | Client flit offered for injection |
| inj_ready | output | 1 | Client flit accepted this cycle |
| x_out | output | FLIT_W | Registered flit leaving on the X ring |
| y_out | output | FLIT_W | Registered flit leaving on the Y ring |
| dlv_out | output | FLIT_W | Registered flit delivered to the client |

## Verification
The router holds no state apart from its three output registers. A wrong select decision therefore shows up on the outputs exactly one clock after the inputs that caused it. Possible symptoms are a flit on the wrong link, a flit that vanishes, or one flit that appears twice. A wrong `inj_ready` is visible in the same cycle, before any clock edge. The bench compares all four outputs against a behavioural model every cycle, so any of these faults is reported at the first cycle in which it occurs.

// File: rtl/tor_pkg.sv
package tor_pkg;

  // Output each flit wants at this node
  typedef enum logic [1:0] {
    WANT_NONE  = 2'd0,
    WANT_X     = 2'd1,
    WANT_Y     = 2'd2,
    WANT_LOCAL = 2'd3
  } want_e;

  // Source chosen for each output register
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_X    = 2'd1,
    SRC_Y    = 2'd2,
    SRC_C    = 2'd3
  } src_e;

  localparam int NUM_OUT = 3;
  localparam int OUT_X   = 0;
  localparam int OUT_Y   = 1;
  localparam int OUT_L   = 2;

endpackage

// File: rtl/tor_rst_sync.sv
module tor_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/tor_route_dec.sv
module tor_route_dec
  import tor_pkg::*;
(
  input  logic  valid,
  input  logic  x_hit,
  input  logic  y_hit,
  output want_e want
);
  // Dimension order: finish X, then Y, then deliver
  always_comb begin
    if (!valid)      want = WANT_NONE;
    else if (!x_hit) want = WANT_X;
    else if (!y_hit) want = WANT_Y;
    else             want = WANT_LOCAL;
  end
endmodule

// File: rtl/tor_arbiter.sv
module tor_arbiter
  import tor_pkg::*;
(
  input  want_e want_x,
  input  want_e want_y,
  input  want_e want_c,
  output src_e  src_xo,
  output src_e  src_yo,
  output src_e  src_lo,
  output logic  inj_ok
);
  logic y_loc, y_fwd, x_loc, x_turn, x_pass;
  logic free_x, free_y, free_l;

  always_comb begin
    // Y ring traffic ranks first
    y_loc  = (want_y == WANT_LOCAL);
    y_fwd  = (want_y == WANT_Y);
    // X ring traffic takes what is left, else stays on X
    x_loc  = (want_x == WANT_LOCAL) && !y_loc;
    x_turn = (want_x == WANT_Y) && !y_fwd;
    x_pass = (want_x != WANT_NONE) && !x_loc && !x_turn;

    free_x = !x_pass;
    free_y = !(y_fwd || x_turn);
    free_l = !(y_loc || x_loc);

    unique case (want_c)
      WANT_X:     inj_ok = free_x;
      WANT_Y:     inj_ok = free_y;
      WANT_LOCAL: inj_ok = free_l;
      default:    inj_ok = 1'b0;
    endcase

    if (x_pass)                               src_xo = SRC_X;
    else if (inj_ok && want_c == WANT_X)      src_xo = SRC_C;
    else                                      src_xo = SRC_NONE;

    if (y_fwd)                                src_yo = SRC_Y;
    else if (x_turn)                          src_yo = SRC_X;
    else if (inj_ok && want_c == WANT_Y)      src_yo = SRC_C;
    else                                      src_yo = SRC_NONE;

    if (y_loc)                                src_lo = SRC_Y;
    else if (x_loc)                           src_lo = SRC_X;
    else if (inj_ok && want_c == WANT_LOCAL)  src_lo = SRC_C;
    else                                      src_lo = SRC_NONE;
  end
endmodule

// File: rtl/tor_out_reg.sv
module tor_out_reg
  import tor_pkg::*;
#(
  parameter int FW = 37
) (
  input  logic          clk,
  input  logic          rst_n,
  input  src_e          src,
  input  logic [FW-1:0] from_x,
  input  logic [FW-1:0] from_y,
  input  logic [FW-1:0] from_c,
  output logic [FW-1:0] q
);
  logic [FW-1:0] nxt;
  logic          en;

  always_comb begin
    unique case (src)
      SRC_X:   nxt = from_x;
      SRC_Y:   nxt = from_y;
      SRC_C:   nxt = from_c;
      default: nxt = '0;
    endcase
    // Load only when a flit arrives or one must be cleared
    en = nxt[0] | q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/tor_router.sv
module tor_router
  import tor_pkg::*;
#(
  parameter int X_NODES   = 4,
  parameter int Y_NODES   = 4,
  parameter int PAYLOAD_W = 32,
  localparam int XW       = $clog2(X_NODES),
  localparam int YW       = $clog2(Y_NODES),
  localparam int FLIT_W   = 1 + XW + YW + PAYLOAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XW-1:0]     my_x,
  input  logic [YW-1:0]     my_y,
  input  logic [FLIT_W-1:0] x_in,
  input  logic [FLIT_W-1:0] y_in,
  input  logic [FLIT_W-1:0] inj_flit,
  output logic              inj_ready,
  output logic [FLIT_W-1:0] x_out,
  output logic [FLIT_W-1:0] y_out,
  output logic [FLIT_W-1:0] dlv_out
);
  localparam int DX_LO = 1;
  localparam int DY_LO = 1 + XW;

  logic rst_sync_n;

  tor_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Per-input coordinate match; the Y ring input has already finished X
  logic  x_hit_x, y_hit_x, y_hit_y, x_hit_c, y_hit_c;
  want_e want_x, want_y, want_c;

  assign x_hit_x = (x_in[DX_LO +: XW] == my_x);
  assign y_hit_x = (x_in[DY_LO +: YW] == my_y);
  assign y_hit_y = (y_in[DY_LO +: YW] == my_y);
  assign x_hit_c = (inj_flit[DX_LO +: XW] == my_x);
  assign y_hit_c = (inj_flit[DY_LO +: YW] == my_y);

  tor_route_dec u_dec_x (.valid(x_in[0]),     .x_hit(x_hit_x), .y_hit(y_hit_x), .want(want_x));
  tor_route_dec u_dec_y (.valid(y_in[0]),     .x_hit(1'b1),    .y_hit(y_hit_y), .want(want_y));
  tor_route_dec u_dec_c (.valid(inj_flit[0]), .x_hit(x_hit_c), .y_hit(y_hit_c), .want(want_c));

  src_e src_arr [NUM_OUT];

  tor_arbiter u_arb (
    .want_x (want_x),
    .want_y (want_y),
    .want_c (want_c),
    .src_xo (src_arr[OUT_X]),
    .src_yo (src_arr[OUT_Y]),
    .src_lo (src_arr[OUT_L]),
    .inj_ok (inj_ready)
  );

  logic [FLIT_W-1:0] q_arr [NUM_OUT];

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    tor_out_reg #(.FW(FLIT_W)) u_reg (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .src    (src_arr[g]),
      .from_x (x_in),
      .from_y (y_in),
      .from_c (inj_flit),
      .q      (q_arr[g])
    );
  end

  assign x_out   = q_arr[OUT_X];
  assign y_out   = q_arr[OUT_Y];
  assign dlv_out = q_arr[OUT_L];

endmodule

// File: rtl/tor_router_chk.sv
module tor_router_chk #(
  parameter int XW = 2,
  parameter int YW = 2,
  parameter int FW = 37
) (
  input logic          clk,
  input logic          rst_n,
  input logic [XW-1:0] my_x,
  input logic [YW-1:0] my_y,
  input logic [FW-1:0] x_in,
  input logic [FW-1:0] y_in,
  input logic [FW-1:0] inj_flit,
  input logic          inj_ready,
  input logic [FW-1:0] x_out,
  input logic [FW-1:0] y_out,
  input logic [FW-1:0] dlv_out
);
  localparam int DX_LO = 1;
  localparam int DY_LO = 1 + XW;

  assert_ready_needs_flit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inj_ready |-> inj_flit[0]);

  assert_inj_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inj_ready |=> (x_out == $past(inj_flit) || y_out == $past(inj_flit) ||
                   dlv_out == $past(inj_flit)));

  assert_y_deliver_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (y_in[0] && y_in[DY_LO +: YW] == my_y) |=> dlv_out == $past(y_in));

  assert_y_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (y_in[0] && y_in[DY_LO +: YW] != my_y) |=> y_out == $past(y_in));

  assert_x_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (x_in[0] && x_in[DX_LO +: XW] != my_x) |=> x_out == $past(x_in));

  assert_no_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (x_in[0] || y_in[0]) |=>
      $countones({x_out[0], y_out[0], dlv_out[0]}) >= $countones($past({x_in[0], y_in[0]})));

endmodule

bind tor_router tor_router_chk #(.XW(XW), .YW(YW), .FW(FLIT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .my_x      (my_x),
  .my_y      (my_y),
  .x_in      (x_in),
  .y_in      (y_in),
  .inj_flit  (inj_flit),
  .inj_ready (inj_ready),
  .x_out     (x_out),
  .y_out     (y_out),
  .dlv_out   (dlv_out)
);

// File: tb/tor_router_test.sv
`timescale 1ns/1ps
module tor_router_test;
  localparam int XN = 4;
  localparam int YN = 4;
  localparam int PW = 32;
  localparam int XW = 2;
  localparam int YW = 2;
  localparam int FW = 1 + XW + YW + PW;

  logic clk = 1'b0;
  logic rst_n;
  logic [XW-1:0] my_x;
  logic [YW-1:0] my_y;
  logic [FW-1:0] x_in, y_in, inj;
  logic inj_ready;
  logic [FW-1:0] x_out, y_out, dlv_out;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int mx = 1;
  int my = 2;

  always #2.5 clk = ~clk;

  tor_router #(.X_NODES(XN), .Y_NODES(YN), .PAYLOAD_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .x_in(x_in), .y_in(y_in), .inj_flit(inj), .inj_ready(inj_ready),
    .x_out(x_out), .y_out(y_out), .dlv_out(dlv_out)
  );

  function automatic logic [FW-1:0] mk(bit v, int dx, int dy, int p);
    logic [XW-1:0] cx = dx[XW-1:0];
    logic [YW-1:0] cy = dy[YW-1:0];
    logic [PW-1:0] pl = p[PW-1:0];
    return {pl, cy, cx, v};
  endfunction

  function automatic int col(logic [FW-1:0] f); return int'(f[XW:1]); endfunction
  function automatic int row(logic [FW-1:0] f); return int'(f[XW+YW:XW+1]); endfunction

  // Behavioural model of one cycle
  logic [FW-1:0] ex, ey, ed;
  bit erdy;

  task automatic predict(input logic [FW-1:0] xi, yi, ci);
    bit y_busy = 0, d_busy = 0, x_busy = 0;
    ex = '0; ey = '0; ed = '0; erdy = 0;
    if (yi[0]) begin
      if (row(yi) == my) begin ed = yi; d_busy = 1; end
      else begin ey = yi; y_busy = 1; end
    end
    if (xi[0]) begin
      if (col(xi) != mx) begin ex = xi; x_busy = 1; end
      else if (row(xi) != my) begin
        if (!y_busy) begin ey = xi; y_busy = 1; end
        else begin ex = xi; x_busy = 1; end
      end else begin
        if (!d_busy) begin ed = xi; d_busy = 1; end
        else begin ex = xi; x_busy = 1; end
      end
    end
    if (ci[0]) begin
      if (col(ci) != mx) begin
        if (!x_busy) begin ex = ci; erdy = 1; end
      end else if (row(ci) != my) begin
        if (!y_busy) begin ey = ci; erdy = 1; end
      end else begin
        if (!d_busy) begin ed = ci; erdy = 1; end
      end
    end
  endtask

  task automatic chk(input logic [FW-1:0] act, exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, compare ready now, outputs after the rising edge
  task automatic step(input logic [FW-1:0] xi, yi, ci, input string tag);
    @(negedge clk);
    x_in = xi; y_in = yi; inj = ci;
    #1;
    predict(xi, yi, ci);
    chk({{(FW-1){1'b0}}, inj_ready}, {{(FW-1){1'b0}}, erdy}, {tag, " R8 ready"});
    @(posedge clk);
    #1;
    chk(x_out, ex, {tag, " x_out"});
    chk(y_out, ey, {tag, " y_out"});
    chk(dlv_out, ed, {tag, " dlv_out"});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] a, b, c;
    my_x = XW'(mx); my_y = YW'(my);
    x_in = '0; y_in = '0; inj = '0;
    rst_n = 1'b0;
    // R1: outputs idle under reset, even with traffic offered
    repeat (3) @(posedge clk);
    x_in = mk(1, 3, 0, 32'h11); y_in = mk(1, 1, 3, 32'h22);
    @(negedge clk);
    chk({x_out[0], y_out[0], dlv_out[0]}, 3'b000, "R1 valid bits in reset");
    x_in = '0; y_in = '0;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk({x_out[0], y_out[0], dlv_out[0]}, 3'b000, "R1 valid bits after release");
    repeat (4) @(posedge clk);

    // R8/R7: local flit injected and delivered at the same node
    a = mk(1, mx, my, 32'hC0FFEE01);
    step('0, '0, a, "local inject");
    chk(dlv_out, a, "R8 local inject delivered intact (R2)");

    // R5/R4: flits heading across the wrap point of both rings
    a = mk(1, 0, 1, 32'hA5A5_0001);
    b = mk(1, 1, 1, 32'h5A5A_0002);
    step(a, b, '0, "wrap");
    chk(x_out, a, "R5 X wrap pass");
    chk(y_out, b, "R4 Y wrap pass");

    // R6: turn blocked by Y traffic, deflected onto X
    a = mk(1, mx, 0, 32'hDEF1_0001);
    b = mk(1, mx, 3, 32'hDEF1_0002);
    step(a, b, '0, "turn blocked");
    chk(x_out, a, "R6 deflected onto X");
    chk(y_out, b, "R6 Y keeps priority");
    // R6: same turn with Y free takes the Y output
    step(a, '0, '0, "turn free");
    chk(y_out, a, "R6 turn onto Y");

    // R7: arrived X flit while Y delivers is deflected
    a = mk(1, mx, my, 32'h7777_0001);
    b = mk(1, 0, my, 32'h7777_0002);
    step(a, b, '0, "deliver clash");
    chk(dlv_out, b, "R3 Y delivered");
    chk(x_out, a, "R7 X deflected");

    // R8: client refused when its X target is held by ring traffic
    a = mk(1, 3, 0, 32'h0B0B_0001);
    c = mk(1, 2, 0, 32'h0B0B_0002);
    step(a, '0, c, "inject refused");
    chk(x_out, a, "R8 refused flit absent from X");
    chk({y_out[0], dlv_out[0]}, 2'b00, "R8 refused flit absent elsewhere");

    // R8: client targeting Y while X takes X is accepted
    c = mk(1, mx, 3, 32'h0C0C_0001);
    step(a, '0, c, "inject to Y");
    chk(y_out, c, "R8 accepted into Y");

    // R2/R9: mixed random traffic against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [FW-1:0] rx, ry, rc;
      rx = mk(($urandom % 4) != 0, $urandom % XN, $urandom % YN, $urandom);
      ry = mk(($urandom % 3) != 0, mx, $urandom % YN, $urandom);
      rc = mk(($urandom % 2) != 0, $urandom % XN, $urandom % YN, $urandom);
      step(rx, ry, rc, "R9 random");
    end

    step('0, '0, '0, "drain");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule